// File: doc/BRIEF.md
# Palette-Indexed Pixel Unpacker

This block turns a stream of 32-bit frame-data words into a stream of 16-bit 5:6:5 pixels for a TFT panel. A three-bit depth code selects how each word is cut into pixels. The four shallow depths (1, 2, 4 and 8 bits per pixel) treat each pixel as an index into a 256 x 16-bit colour table. The direct-colour depths (16-bit 1:5:5:5, 16-bit 5:6:5, 12-bit 4:4:4 and 24-bit) repack the pixel bits without a lookup.

A separate write port loads the colour table at any time. Three static controls shape the data. The first reverses the byte order of each word. The second reverses the order of pixels inside a byte for the sub-byte depths. The third exchanges the red and blue fields of every output pixel. Words enter through a valid/ready handshake and pixels leave through another. The table read takes one cycle, and the output stage is timed to match it.

Output pixel layout: bits 15:11 blue, 10:5 green, 4:0 red.

Top module: `pxconv_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid is 0 and inReady is 1.
- R2: The depth code sets the number of pixels per word: 000 gives 32 (1 bpp), 001 gives 16 (2 bpp), 010 gives 8 (4 bpp), 011 gives 4 (8 bpp), 100 gives 2 (16-bit 1:5:5:5), 110 gives 2 (5:6:5), 111 gives 2 (4:4:4) and 101 gives 1 (24-bit).
- R3: A colour-table entry holds red in bits 4:0, green in bits 9:5, blue in bits 14:10 and an intensity bit in 15. The entry is output as {blue, green, intensity, red}, so the intensity bit becomes the green LSB.
- R4: For codes 000 to 011, each pixel's bits are zero-extended to 8 bits and used to look up the colour table. Pixels are taken from the byte in bits 7:0 of the ordered word first, then from higher bytes.
- R5: With byteOrderBig=1, the word's bytes are reversed before unpacking (bits 31:24 become bits 7:0, and so on). With byteOrderBig=0, the word is used as received.
- R6: For codes 000 to 010, with pixOrderBig=0 the first pixel of a byte is in its least significant bits. With pixOrderBig=1 it is in its most significant bits.
- R7: For code 110, each 16-bit halfword (bits 15:0 first) is output unchanged.
- R8: For code 100, each halfword (bits 15:0 first) is converted as a colour-table entry, following R3, without a lookup.
- R9: For code 111, the halfword holds red in bits 3:0, green in 7:4 and blue in 11:8. Red and blue are widened to 5 bits by appending the channel MSB. Green is widened to 6 bits by appending its two MSBs.
- R10: For code 101, one pixel comes from bits 23:0 (red 7:0, green 15:8, blue 23:16), and the top 5, 6 and 5 bits are kept.
- R11: With rbSwap=1, the 5-bit fields in bits 15:11 and 4:0 of every output pixel are exchanged.
- R12: While outValid is high and outReady is low, outValid and outPixel hold steady. Every accepted word gives exactly its pixel count in order, with no extra pixel. Colour-table writes are used by later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| depthSel | input | 3 | Depth code |
| byteOrderBig | input | 1 | Reverse bytes within each word |
| pixOrderBig | input | 1 | First sub-byte pixel in byte MSBs |
| rbSwap | input | 1 | Exchange red and blue on output |
| palWe | input | 1 | Colour-table write strobe |
| palAddr | input | 8 | Colour-table write index |
| palData | input | 16 | Colour-table write value |
| inValid | input | 1 | Word offered |
| inData | input | 32 | Frame-data word |
| inReady | output | 1 | Word accepted when high together with inValid |
| outValid | output | 1 | Pixel available |
| outReady | input | 1 | Downstream takes the pixel |
| outPixel | output | 16 | 5:6:5 pixel |

## Verification
Every depth code is streamed with random words behind a few directed words: all zeros, all ones, a lone LSB and a lone MSB. The lone-bit words show which slot and which byte a pixel comes from, so a wrong pixel order or byte order is caught by position and not only by value. Each mode is repeated with the byte-order, pixel-order and swap controls set, so each control's effect is separated from the plain unpacking. Random stalls on both handshakes test the hold behaviour. Reloading the colour table between runs shows that lookups use its current contents.

// File: rtl/pxconv_pkg.sv
package pxconv_pkg;

  typedef enum logic [2:0] {
    DEPTH_1   = 3'b000,
    DEPTH_2   = 3'b001,
    DEPTH_4   = 3'b010,
    DEPTH_8   = 3'b011,
    DEPTH_555 = 3'b100,
    DEPTH_888 = 3'b101,
    DEPTH_565 = 3'b110,
    DEPTH_444 = 3'b111
  } depth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadWord;
    logic       issue;
    logic [4:0] slot;
  } dp_ctl_t;

  function automatic logic [5:0] pixPerWord(depth_e m);
    case (m)
      DEPTH_1:   return 6'd32;
      DEPTH_2:   return 6'd16;
      DEPTH_4:   return 6'd8;
      DEPTH_8:   return 6'd4;
      DEPTH_888: return 6'd1;
      default:   return 6'd2;
    endcase
  endfunction

  // 1:5:5:5 entry -> 5:6:5, intensity bit as green LSB
  function automatic logic [15:0] entryTo565(logic [15:0] e);
    return {e[14:10], e[9:5], e[15], e[4:0]};
  endfunction

  function automatic logic [15:0] swapRedBlue(logic [15:0] p);
    return {p[4:0], p[10:5], p[15:11]};
  endfunction

endpackage

// File: rtl/pxconv_ctrl.sv
module pxconv_ctrl
  import pxconv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  depth_e  depth,
  input  logic    inValid,
  output logic    inReady,
  input  logic    outReady,
  output logic    outValid,
  output dp_ctl_t ctl
);

  logic       wordHeld;
  logic       pixValid;
  logic [4:0] slotCnt;
  logic       lastSlot;
  logic       advance;
  logic       issue;
  logic       loadWord;

  assign lastSlot = ({1'b0, slotCnt} == (pixPerWord(depth) - 6'd1));
  assign advance  = !pixValid || outReady;
  assign issue    = wordHeld && advance;
  assign inReady  = !wordHeld || (issue && lastSlot);
  assign loadWord = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordHeld <= 1'b0;
      pixValid <= 1'b0;
      slotCnt  <= '0;
    end else begin
      if (advance) pixValid <= issue;
      if (loadWord) begin
        wordHeld <= 1'b1;
        slotCnt  <= '0;
      end else if (issue) begin
        if (lastSlot) wordHeld <= 1'b0;
        else          slotCnt  <= slotCnt + 5'd1;
      end
    end
  end

  assign outValid     = pixValid;
  assign ctl.loadWord = loadWord;
  assign ctl.issue    = issue;
  assign ctl.slot     = slotCnt;

endmodule

// File: rtl/pxconv_dp.sv
module pxconv_dp
  import pxconv_pkg::*;
#(
  parameter int PAL_AW = 8,
  parameter int PIX_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  depth_e            depth,
  input  logic              byteOrderBig,
  input  logic              pixOrderBig,
  input  logic              rbSwap,
  input  logic              palWe,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [PIX_W-1:0]  palData,
  input  logic [WORD_W-1:0] inData,
  output logic [PIX_W-1:0]  outPixel
);

  localparam int PAL_DEPTH = 1 << PAL_AW;
  localparam int NBYTES    = WORD_W / 8;

  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] wordReg;

  // byte reordering happens once, at load
  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    assign ordered[8*b +: 8] = byteOrderBig ? inData[8*(NBYTES-1-b) +: 8]
                                            : inData[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordReg <= '0;
    else if (ctl.loadWord) wordReg <= ordered;
  end

  // one index extractor per sub-word depth
  logic [7:0] subIdx [4];
  for (genvar g = 0; g < 4; g++) begin : g_depth
    localparam int BPP = 1 << g;
    localparam int PPB = 8 >> g;
    logic [1:0]        byteNo;
    logic [2:0]        inByte;
    logic [2:0]        eff;
    logic [4:0]        shAmt;
    logic [WORD_W-1:0] shifted;
    assign byteNo  = 2'(ctl.slot >> (3 - g));
    assign inByte  = ctl.slot[2:0] & 3'(PPB - 1);
    assign eff     = pixOrderBig ? (3'(PPB - 1) - inByte) : inByte;
    assign shAmt   = {byteNo, 3'b000} + (5'(eff) << g);
    assign shifted = wordReg >> shAmt;
    assign subIdx[g] = 8'(shifted[BPP-1:0]);
  end

  logic [PAL_AW-1:0] rdAddr;
  logic [15:0]       half;
  logic [PIX_W-1:0]  directPix;
  logic              isPal;

  assign rdAddr = PAL_AW'(subIdx[depth[1:0]]);
  assign half   = ctl.slot[0] ? wordReg[31:16] : wordReg[15:0];
  assign isPal  = !depth[2];

  always_comb begin
    case (depth)
      DEPTH_555: directPix = entryTo565(half);
      DEPTH_565: directPix = half;
      DEPTH_444: directPix = {half[11:8], half[11], half[7:4], half[7:6],
                              half[3:0], half[3]};
      DEPTH_888: directPix = {wordReg[23:19], wordReg[15:10], wordReg[7:3]};
      default:   directPix = '0;
    endcase
  end

  // colour table: write port free-running, read only on issue
  logic [PIX_W-1:0] palMem [PAL_DEPTH];
  logic [PIX_W-1:0] palQ;

  always_ff @(posedge clk) begin
    if (palWe)     palMem[palAddr] <= palData;
    if (ctl.issue) palQ <= palMem[rdAddr];
  end

  logic [PIX_W-1:0] pixReg;
  logic             usePal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixReg <= '0;
      usePal <= 1'b0;
    end else if (ctl.issue) begin
      pixReg <= directPix;
      usePal <= isPal;
    end
  end

  logic [PIX_W-1:0] prePix;
  assign prePix   = usePal ? entryTo565(palQ) : pixReg;
  assign outPixel = rbSwap ? swapRedBlue(prePix) : prePix;

endmodule

// File: rtl/pxconv_top.sv
module pxconv_top
  import pxconv_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        depthSel,
  input  logic              byteOrderBig,
  input  logic              pixOrderBig,
  input  logic              rbSwap,
  input  logic              palWe,
  input  logic [PAL_AW-1:0] palAddr,
  input  logic [15:0]       palData,
  input  logic              inValid,
  input  logic [31:0]       inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [15:0]       outPixel
);

  depth_e  depth;
  dp_ctl_t ctl;

  assign depth = depth_e'(depthSel);

  pxconv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .depth    (depth),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  pxconv_dp #(.PAL_AW(PAL_AW), .PIX_W(16), .WORD_W(32)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .depth        (depth),
    .byteOrderBig (byteOrderBig),
    .pixOrderBig  (pixOrderBig),
    .rbSwap       (rbSwap),
    .palWe        (palWe),
    .palAddr      (palAddr),
    .palData      (palData),
    .inData       (inData),
    .outPixel     (outPixel)
  );

endmodule

// File: rtl/pxconv_chk.sv
module pxconv_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [15:0] outPixel
);

  logic seenWord;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   seenWord <= 1'b0;
    else if (inValid && inReady) seenWord <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R12
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R12
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outPixel));

  // R12
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> seenWord);

endmodule

bind pxconv_top pxconv_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outPixel (outPixel)
);

// File: tb/sim_pxconv_top.sv
`timescale 1ns/1ps
module sim_pxconv_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  depthSel = '0;
  logic        byteOrderBig = 1'b0, pixOrderBig = 1'b0, rbSwap = 1'b0;
  logic        palWe = 1'b0;
  logic [7:0]  palAddr = '0;
  logic [15:0] palData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady, outValid;
  logic        outReady = 1'b0;
  logic [15:0] outPixel;

  always #2.5 clk = ~clk;

  pxconv_top u0 (
    .clk(clk), .rstN(rstN), .depthSel(depthSel), .byteOrderBig(byteOrderBig),
    .pixOrderBig(pixOrderBig), .rbSwap(rbSwap), .palWe(palWe), .palAddr(palAddr),
    .palData(palData), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timedOut = 0;
  logic [15:0] benchPal [256];
  logic [31:0] srcQ [$];
  logic [15:0] expQ [$];

  function automatic int ppw(input logic [2:0] m);
    case (m)
      3'd0: return 32;
      3'd1: return 16;
      3'd2: return 8;
      3'd3: return 4;
      3'd5: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] cvt(input logic [15:0] e);
    return {e[14:10], e[9:5], e[15], e[4:0]};
  endfunction

  function automatic logic [15:0] expPix(input logic [2:0] m, input logic [31:0] w,
                                         input int k, input bit be, input bit pe,
                                         input bit sw);
    logic [31:0] r;
    logic [15:0] h;
    logic [15:0] p;
    int bpp, per, byteNo, slot, idx;
    r = be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    h = (k == 1) ? r[31:16] : r[15:0];
    case (m)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        bpp = 1 << m;
        per = 8 / bpp;
        byteNo = k / per;
        slot = k % per;
        if (pe) slot = per - 1 - slot;
        idx = int'(r >> (byteNo * 8 + slot * bpp)) & ((1 << bpp) - 1);
        p = cvt(benchPal[idx[7:0]]);
      end
      3'd4: p = cvt(h);
      3'd6: p = h;
      3'd7: p = {h[11:8], h[11], h[7:4], h[7:6], h[3:0], h[3]};
      default: p = {r[23:19], r[15:10], r[7:3]};
    endcase
    if (sw) p = {p[4:0], p[10:5], p[15:11]};
    return p;
  endfunction

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > 150000 && !timedOut) begin
      timedOut = 1;
      fails++;
      $display("FAIL watchdog R12: actual=%0d cycles expected<=150000", cycles);
    end
  endtask

  task automatic progPalette();
    for (int i = 0; i < 256; i++) begin
      tick();
      palWe = 1'b1;
      palAddr = 8'(i);
      palData = 16'($urandom);
      benchPal[i] = palData;
    end
    tick();
    palWe = 1'b0;
  endtask

  task automatic runStream(input logic [2:0] m, input bit be, input bit pe,
                           input bit sw, input int nRand, input string tag);
    logic [31:0] w;
    logic [15:0] e;
    tick();
    depthSel = m; byteOrderBig = be; pixOrderBig = pe; rbSwap = sw;
    for (int i = 0; i < 4 + nRand; i++) begin
      case (i)
        0: w = 32'h0000_0001;
        1: w = 32'h8000_0000;
        2: w = 32'hFFFF_FFFF;
        3: w = 32'h0000_0000;
        default: w = $urandom;
      endcase
      srcQ.push_back(w);
      for (int k = 0; k < ppw(m); k++) expQ.push_back(expPix(m, w, k, be, pe, sw));
    end
    while ((srcQ.size() > 0 || expQ.size() > 0) && !timedOut) begin
      tick();
      inValid  = (srcQ.size() > 0) && ($urandom % 4 != 0);
      inData   = (srcQ.size() > 0) ? srcQ[0] : 32'h0;
      outReady = ($urandom % 3 != 0);
      #1;
      if (outValid && outReady) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s R12 extra pixel: actual=%h expected=none", tag, outPixel);
        end else begin
          e = expQ.pop_front();
          if (outPixel !== e) begin
            fails++;
            $display("FAIL %s mode=%0d: actual=%h expected=%h", tag, m, outPixel, e);
          end
        end
      end
      if (inValid && inReady) void'(srcQ.pop_front());
    end
    tick();
    inValid = 1'b0;
    outReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      checks++;
      if (outValid !== 1'b0) begin
        fails++;
        $display("FAIL R2 R12 trailing pixel: actual=%b expected=0", outValid);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0;
    repeat (3) tick();
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset: actual=%b%b expected=01", outValid, inReady);
    end
    rstN = 1'b1;
    tick();
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 after reset: actual=%b%b expected=01", outValid, inReady);
    end

    progPalette();
    runStream(3'd0, 0, 0, 0, 12, "R4");
    runStream(3'd0, 0, 1, 0, 12, "R6");
    runStream(3'd1, 0, 0, 0, 12, "R2");
    runStream(3'd1, 1, 1, 0, 12, "R6");
    runStream(3'd2, 0, 0, 0, 16, "R4");
    runStream(3'd2, 0, 1, 0, 16, "R6");
    runStream(3'd3, 0, 0, 0, 20, "R3");
    runStream(3'd3, 1, 0, 0, 20, "R5");
    runStream(3'd4, 0, 0, 0, 30, "R8");
    runStream(3'd6, 0, 0, 0, 30, "R7");
    runStream(3'd6, 1, 0, 1, 30, "R11");
    runStream(3'd7, 0, 0, 0, 30, "R9");
    runStream(3'd7, 1, 0, 0, 30, "R5");
    runStream(3'd5, 0, 0, 0, 40, "R10");
    runStream(3'd5, 1, 0, 1, 40, "R11");
    progPalette();
    runStream(3'd3, 0, 0, 1, 20, "R12");
    runStream(3'd1, 0, 0, 0, 10, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule